// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit timer/counter and a watchdog counter that share a single power-of-two prescaler. A 6-bit mode word, written through a write-only strobe, picks where the timer's count events come from: the instruction-cycle enable or an edge on an external clock pin. It also picks which edge of that pin counts, whether the prescaler sits in front of the timer or in front of the watchdog, and the prescale code. The prescaler serves one counter at a time. The counter it does not serve sees its raw events.

The timer can be loaded at any time and its value is always visible on an output. The watchdog counts ticks from a free-running slow oscillator that lives outside the block. When it reaches its period it emits a one-cycle time-out pulse and starts over. A clear strobe restarts it. While the sleep indicator is high, the instruction-cycle events stop reaching the timer. Watchdog ticks keep counting during sleep.

Top module: `tmr_wdt_unit`

## Requirements
- R1: Reset sets the timer to 0x00, holds the time-out low, and loads the mode word with 6'h3F. In that state the source is the external pin, falling edges count, the prescaler serves the watchdog, and the code is 7.
- R2: Mode word fields: bits 2:0 are the prescale code; bit 3 gives the prescaler to the watchdog when 1 and to the timer when 0; bit 4 selects falling (1) or rising (0) pin edges; bit 5 selects the pin (1) or the instruction-cycle enable (0) as the timer source.
- R3: With internal source and no prescaler on the timer, the timer adds one on each clock with `cyc_en` high and `sleep` low, and wraps from 0xFF to 0x00. `sleep` high stops these increments.
- R4: With external source, each selected edge on `ext_clk` is counted. A pin change driven before clock edge k shows up in `tmr_q` after edge k+2: two synchronizer stages, then an edge register.
- R5: With the prescaler on the timer, code n gives one timer increment per 2^(n+1) source events.
- R6: With the prescaler on the watchdog, code n gives one watchdog step per 2^n watchdog ticks.
- R7: A timer write shows in `tmr_q` on the next cycle. It wins over an increment in the same cycle, and it restarts the prescaler count when the prescaler serves the timer.
- R8: The watchdog raises `wdt_timeout` for exactly one cycle on its WDT_PERIOD-th step after a clear or a previous time-out. It then counts again from zero.
- R9: `wdt_clr` zeroes the watchdog count and suppresses a time-out in that cycle. It zeroes the prescaler only when the prescaler serves the watchdog.
- R10: Any mode write restarts the prescaler count. Events in the write cycle are routed by the old mode.
- R11: The prescaler output never drives both counters. With the prescaler on the watchdog, the timer counts raw source events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per instruction cycle |
| sleep | input | 1 | High while the core is in power-saving sleep |
| ext_clk | input | 1 | Asynchronous external timer clock pin |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| wdt_clr | input | 1 | Watchdog clear strobe |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 6 | Mode word value |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| tmr_q | output | 8 | Current timer value |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The timer is driven with a steady cycle enable that runs it through a wrap, with sleep and idle gaps, and with slow pin toggles on each edge polarity. The pin cases also show the synchronizer latency and that only the selected edge counts. Prescaled runs at the shortest and longest codes tell the timer-side ratio table from the one-step-shorter watchdog table. Strobes placed part-way through a prescale count show which events restart that count and which leave it running. A long random phase mixes mode changes, loads and clears against the reference model on every clock.

// File: rtl/tw_pkg.sv
// Package: shared types for the shared-prescaler timer/watchdog block.
// Assumes the mode word is six bits; field order matches the bit positions
// that software writes.
package tw_pkg;
    localparam int TW_RATE_W = 3;

    typedef struct packed {
        logic                 src_ext;   // bit 5: 1 = external pin
        logic                 edge_fall; // bit 4: 1 = falling edges
        logic                 psc_wdt;   // bit 3: 1 = prescaler on watchdog
        logic [TW_RATE_W-1:0] rate;      // bits 2:0: prescale code
    } tw_mode_t;

    localparam tw_mode_t TW_MODE_RST = '{src_ext: 1'b1, edge_fall: 1'b1,
                                         psc_wdt: 1'b1, rate: '1};
endpackage

// File: rtl/tw_edge_sync.sv
// Module: tw_edge_sync
// Brings an asynchronous pin into the clock domain through STAGES flops,
// then flags one selected edge (rising or falling) per transition.
// Assumes STAGES >= 2 and that the pin is slower than half the clock.
module tw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);
    logic [STAGES-1:0] stg;
    logic              prev;
    logic              rise, fall;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], pin};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= stg[STAGES-1];
    end

    // Choose the edge polarity requested by the mode word.
    always_comb begin
        rise     = stg[STAGES-1] & ~prev;
        fall     = ~stg[STAGES-1] & prev;
        edge_evt = fall_sel ? fall : rise;
    end

    // R4: the same polarity cannot be flagged on two clocks in a row.
    a_r4_edge_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (!edge_evt || fall_sel != $past(fall_sel)));
endmodule

// File: rtl/tw_prescaler.sv
// Module: tw_prescaler
// Power-of-two event divider. It passes one event in every 2^n inputs for
// the watchdog and one in every 2^(n+1) inputs for the timer.
// Assumes CNT_W >= 2**RATE_W so that the longest ratio fits in the counter.
module tw_prescaler #(
    parameter int CNT_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    input  logic              for_wdt,
    output logic              out_evt
);
    localparam int SHIFT_W = RATE_W + 1;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   mask;
    logic [SHIFT_W-1:0] shift;
    logic [CNT_W-1:0]   ones;

    // Build the terminal-count mask from the code and the current owner.
    always_comb begin
        ones    = '1;
        shift   = {1'b0, rate} + SHIFT_W'(!for_wdt);
        mask    = ~(ones << shift);
        out_evt = evt & ~clr & ((cnt & mask) == mask);
    end

    // Count input events; a clear wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (evt) cnt <= cnt + 1'b1;
    end

    // R10: a clear leaves the count at zero.
    a_r10_psc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R6: code 0 on the watchdog passes every event through.
    a_r6_wdt_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (for_wdt && rate == '0 && evt && !clr) |-> out_evt);
endmodule

// File: rtl/tw_wdog.sv
// Module: tw_wdog
// Watchdog step counter. On the PERIOD-th step it sends a registered
// one-cycle pulse and starts over. A clear restarts it at once.
// Assumes PERIOD >= 2.
module tw_wdog #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic timeout
);
    localparam int W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;
    logic         at_last;

    // Detect the final step of a period.
    always_comb at_last = (cnt == LAST);

    // Advance, wrap, or clear the step count.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (evt && at_last) cnt <= '0;
        else if (evt)           cnt <= cnt + 1'b1;
    end

    // Register the time-out pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= evt & at_last & ~clr;
    end

    // R8: the time-out never lasts two cycles.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
    // R9: a clear restarts the count and suppresses the pulse.
    a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !timeout));
endmodule

// File: rtl/tmr_wdt_unit.sv
// Module: tmr_wdt_unit (top)
// Timer/counter and watchdog sharing one prescaler. Holds the mode word,
// routes source events and prescaler output to one owner, and keeps the
// timer register. Assumes cyc_en, wdt_tick and the strobes are synchronous
// to clk; ext_clk may be asynchronous.
module tmr_wdt_unit
    import tw_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WDT_PERIOD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             sleep,
    input  logic             ext_clk,
    input  logic             wdt_tick,
    input  logic             wdt_clr,
    input  logic             mode_we,
    input  logic [5:0]       mode_wdata,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    output logic [TMR_W-1:0] tmr_q,
    output logic             wdt_timeout
);
    tw_mode_t mode_q;
    logic     ext_evt, src_evt, psc_in, psc_clr, psc_out;
    logic     tmr_inc, wdt_evt;

    // Hold the write-only mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= TW_MODE_RST;
        else if (mode_we) mode_q <= tw_mode_t'(mode_wdata);
    end

    tw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk),
        .fall_sel(mode_q.edge_fall), .edge_evt(ext_evt)
    );

    // Pick the timer source and feed the prescaler from its owner.
    always_comb begin
        src_evt = mode_q.src_ext ? ext_evt : (cyc_en & ~sleep);
        psc_in  = mode_q.psc_wdt ? wdt_tick : src_evt;
        psc_clr = mode_we | (tmr_we & ~mode_q.psc_wdt) | (wdt_clr & mode_q.psc_wdt);
    end

    tw_prescaler #(.CNT_W(PSC_W), .RATE_W(TW_RATE_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .evt(psc_in), .clr(psc_clr),
        .rate(mode_q.rate), .for_wdt(mode_q.psc_wdt), .out_evt(psc_out)
    );

    // Route the prescaler output to exactly one counter.
    always_comb begin
        tmr_inc = mode_q.psc_wdt ? src_evt : psc_out;
        wdt_evt = mode_q.psc_wdt ? psc_out : wdt_tick;
    end

    // Load or advance the timer; a load wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       tmr_q <= '0;
        else if (tmr_we)  tmr_q <= tmr_wdata;
        else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end

    tw_wdog #(.PERIOD(WDT_PERIOD)) u_wdog (
        .clk(clk), .rst_n(rst_n), .evt(wdt_evt), .clr(wdt_clr),
        .timeout(wdt_timeout)
    );

    // R7: a write lands in the timer on the next cycle.
    a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> (tmr_q == $past(tmr_wdata)));
    // R3: without a write the timer holds or steps by one, wrapping.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_we |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1));
    // R11: with the prescaler on the watchdog, only raw source events move the timer.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.psc_wdt && !src_evt && !tmr_we) |=> $stable(tmr_q));
    // R3: sleep stops internal-source counting.
    a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.src_ext && mode_q.psc_wdt && sleep && !tmr_we) |=> $stable(tmr_q));
endmodule

// File: tb/sim_tmr_wdt_unit.sv
module sim_tmr_wdt_unit;
    localparam int PER = 16;

    logic clk = 0, rst_n = 0;
    logic cyc_en = 0, sleep = 0, ext_clk = 0, wdt_tick = 0, wdt_clr = 0;
    logic mode_we = 0, tmr_we = 0;
    logic [5:0] mode_wdata = 0;
    logic [7:0] tmr_wdata = 0;
    logic [7:0] tmr_q;
    logic       wdt_timeout;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_tmr = 0, pc = 0, wc = 0;
    bit  m_to = 0;
    bit [5:0] m_mode = 6'h3F;
    bit  p1 = 0, p2 = 0, p3 = 0;

    always #5 clk = ~clk;

    tmr_wdt_unit #(.WDT_PERIOD(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sleep(sleep),
        .ext_clk(ext_clk), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .tmr_we(tmr_we),
        .tmr_wdata(tmr_wdata), .tmr_q(tmr_q), .wdt_timeout(wdt_timeout)
    );

    // Behavioural model, advanced once per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_to = 0; m_mode = 6'h3F; p1 = 0; p2 = 0; p3 = 0; pc = 0; wc = 0;
        end else begin
            bit ext_ev, src_ev, asg, pin_ev, pout, pclr, tinc, wev;
            int ratio;
            ext_ev = m_mode[4] ? (p3 && !p2) : (!p3 && p2);
            src_ev = m_mode[5] ? ext_ev : (cyc_en && !sleep);
            asg    = m_mode[3];
            ratio  = asg ? (1 << m_mode[2:0]) : (2 << m_mode[2:0]);
            pin_ev = asg ? wdt_tick : src_ev;
            pclr   = mode_we || (tmr_we && !asg) || (wdt_clr && asg);
            pout   = 0;
            if (pclr) pc = 0;
            else if (pin_ev) begin
                pc++;
                if (pc == ratio) begin pout = 1; pc = 0; end
            end
            tinc = asg ? src_ev : pout;
            if (tmr_we) m_tmr = tmr_wdata;
            else if (tinc) m_tmr = (m_tmr + 1) % 256;
            wev = asg ? pout : wdt_tick;
            m_to = 0;
            if (wdt_clr) wc = 0;
            else if (wev) begin
                if (wc == PER - 1) begin wc = 0; m_to = 1; end
                else wc++;
            end
            if (mode_we) m_mode = mode_wdata;
            p3 = p2; p2 = p1; p1 = ext_clk;
        end
    end

    // Compare with the model every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (tmr_q !== 8'(m_tmr) || wdt_timeout !== m_to) begin
                fails++;
                $display("FAIL %s model: tmr=%0h to=%0b expected tmr=%0h to=%0b",
                         cur_req, tmr_q, wdt_timeout, m_tmr, m_to);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(logic [5:0] v);
        mode_we = 1; mode_wdata = v; run(1); mode_we = 0;
    endtask

    task automatic wr_tmr(logic [7:0] v);
        tmr_we = 1; tmr_wdata = v; run(1); tmr_we = 0;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1; run(1); wdt_clr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog on the bench itself.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected fewer than 150000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        int pulses;
        run(3);
        rst_n = 1;
        run(1);
        // R1: reset values
        chk("R1 timer reset", tmr_q, 0);
        chk("R1 timeout reset", wdt_timeout, 0);
        // R1/R4: default mode counts falling pin edges, not rising ones
        cur_req = "R1";
        ext_clk = 1; run(4);
        chk("R1 rising ignored by default", tmr_q, 0);
        ext_clk = 0; run(4);
        chk("R1 default falling counted", tmr_q, 1);

        // R4: latency of the external path, rising edge
        cur_req = "R4";
        wr_mode(6'h28);
        ext_clk = 1; run(2);
        chk("R4 not yet after two edges", tmr_q, 1);
        run(1);
        chk("R4 counted after third edge", tmr_q, 2);
        ext_clk = 0; run(4);
        chk("R4 falling ignored in rising mode", tmr_q, 2);

        // R3: internal source, wrap, sleep
        cur_req = "R3";
        wr_mode(6'h08);
        wr_tmr(8'hFA);
        cyc_en = 1; run(10);
        chk("R3 wrap FA+10", tmr_q, 8'h04);
        sleep = 1; run(5);
        chk("R3 sleep holds", tmr_q, 8'h04);
        sleep = 0; cyc_en = 0; run(5);
        chk("R3 no enable holds", tmr_q, 8'h04);

        // R5: prescaler on timer
        cur_req = "R5";
        wr_mode(6'h01); wr_tmr(0);
        cyc_en = 1; run(12); cyc_en = 0;
        chk("R5 code1 ratio 4", tmr_q, 3);
        wr_mode(6'h00); wr_tmr(0);
        cyc_en = 1; run(9); cyc_en = 0;
        chk("R5 code0 ratio 2", tmr_q, 4);
        wr_mode(6'h07); wr_tmr(0);
        cyc_en = 1; run(512); cyc_en = 0;
        chk("R5 code7 ratio 256", tmr_q, 2);

        // R4: falling edges through the prescaler, code1
        cur_req = "R4";
        wr_mode(6'h31); wr_tmr(0);
        for (int i = 0; i < 8; i++) begin
            ext_clk = 1; run(2); ext_clk = 0; run(2);
        end
        run(4);
        chk("R4 eight falls over ratio 4", tmr_q, 2);

        // R6/R11: prescaler on watchdog code2, timer counts raw
        cur_req = "R6";
        wr_mode(6'h0A); wr_tmr(0);
        pulse_clr();
        pulses = 0;
        wdt_tick = 1; cyc_en = 1;
        for (int i = 0; i < 130; i++) begin
            run(1);
            if (wdt_timeout) pulses++;
        end
        wdt_tick = 0; cyc_en = 0;
        chk("R6 code2 two timeouts in 130 ticks", pulses, 2);
        chk("R11 timer counts raw cycles", tmr_q, 130);

        // R8: code0 on watchdog, single pulse at PER
        cur_req = "R8";
        wr_mode(6'h08); pulse_clr();
        wdt_tick = 1; run(PER - 1);
        chk("R8 no timeout before period", wdt_timeout, 0);
        run(1);
        chk("R8 timeout at period", wdt_timeout, 1);
        run(1);
        chk("R8 single cycle pulse", wdt_timeout, 0);
        wdt_tick = 0;

        // R9: clear restarts the watchdog
        cur_req = "R9";
        pulse_clr();
        wdt_tick = 1; run(10); wdt_tick = 0;
        pulse_clr();
        wdt_tick = 1; run(PER - 1);
        chk("R9 clear restarted count", wdt_timeout, 0);
        run(1);
        chk("R9 timeout after full period", wdt_timeout, 1);
        wdt_tick = 0; run(1);
        // R9: clear does not touch a timer-owned prescaler
        wr_mode(6'h01); wr_tmr(0);
        cyc_en = 1; run(2);
        wdt_clr = 1; run(1); wdt_clr = 0;
        run(1); cyc_en = 0;
        chk("R9 timer prescaler kept", tmr_q, 1);

        // R10: mode write restarts the prescaler
        cur_req = "R10";
        wr_tmr(0);
        cyc_en = 1; run(3); cyc_en = 0;
        wr_mode(6'h01);
        cyc_en = 1; run(3);
        chk("R10 count restarted", tmr_q, 0);
        run(1); cyc_en = 0;
        chk("R10 fourth event after restart", tmr_q, 1);

        // R7: write precedence and prescaler restart
        cur_req = "R7";
        wr_mode(6'h08);
        cyc_en = 1;
        wr_tmr(8'h55);
        chk("R7 write wins over increment", tmr_q, 8'h55);
        run(1);
        chk("R7 counting resumes", tmr_q, 8'h56);
        cyc_en = 0;
        wr_mode(6'h01); wr_tmr(0);
        cyc_en = 1; run(3);
        wr_tmr(8'h10);
        run(3);
        chk("R7 write restarted prescaler", tmr_q, 8'h10);
        run(1); cyc_en = 0;
        chk("R7 increment after restart", tmr_q, 8'h11);

        // R2: mixed random traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            cyc_en   = $urandom_range(0, 3) != 0;
            sleep    = $urandom_range(0, 15) == 0;
            wdt_tick = $urandom_range(0, 1);
            wdt_clr  = $urandom_range(0, 63) == 0;
            if ($urandom_range(0, 5) == 0) ext_clk = ~ext_clk;
            mode_we  = $urandom_range(0, 199) == 0;
            mode_wdata = 6'($urandom);
            tmr_we   = $urandom_range(0, 99) == 0;
            tmr_wdata = 8'($urandom);
            run(1);
        end
        cyc_en = 0; sleep = 0; wdt_tick = 0; wdt_clr = 0; mode_we = 0; tmr_we = 0;
        run(4);
        summary();
        $finish;
    end
endmodule